// File: doc/BRIEF.md
# Inbound Message Queue with Recycle and Address-Tagged Parking

This block is the receive queue in front of a protocol controller. Messages arrive on a push port and wait in a main queue of eight slots. The controller sees the oldest message through a head view. Each cycle it can apply one head operation to that message:

- **dequeue** consumes it.
- **recycle** sends it to the back of the queue, so the messages behind it get served at once.
- **stall** moves it into a four-slot parking store. The store keeps the message's own address as its tag.

Parked messages sit outside the service order until the controller issues a wake. A wake either names one address, which releases every parked message carrying that tag, or releases everything. Released messages go back to the tail of the main queue, where they are processed again.

Each parked message keeps its slot in the main queue reserved. A wake therefore never finds the main queue short of room. New pushes are refused once the main queue and the parking store together hold eight messages.

The head-operation decode is an enumerated command (NONE, DEQ, RECYCLE, STALL), chosen with a unique case. An operation on an empty queue is forced to NONE. A stall is forced to NONE when the parking store is full.

Each cycle the next main-queue contents are built in a fixed order:

1. the surviving messages behind the head, oldest first;
2. the recycled head, if any;
3. the woken messages, in parking order;
4. the pushed message, if accepted.

Top module: `stall_wait_queue`

## Requirements
- R1: During and after reset with no activity, `q_empty_o` and `park_empty_o` are 1, and `head_valid_o`, `q_full_o` and `park_full_o` are 0.
- R2: An accepted push appends the message at the tail. `head_valid_o` equals the inverse of `q_empty_o`, and the head view always shows the oldest message in the main queue.
- R3: `op_i`=1 (dequeue) removes the head at the next rising edge, so at most one message leaves per cycle. Any `op_i` value applied while the main queue is empty has no effect.
- R4: `op_i`=2 (recycle) moves the head message to the tail of the main queue. The relative order of the other messages is unchanged.
- R5: `op_i`=3 (stall) removes the head and parks it, tagged with its address. If the parking store already holds 4 messages, the stall is refused and the message stays at the head.
- R6: With `wake_i`=1, every parked message whose address equals `wake_addr_i` returns to the tail of the main queue in parking order. Non-matching parked messages stay parked in their order.
- R7: With `wake_all_i`=1, every parked message returns to the main queue in parking order. `wake_all_i` takes precedence over `wake_i`.
- R8: When several things reach the main queue in one cycle, they are appended in this order: recycled head, then woken messages, then the pushed message.
- R9: `q_full_o` is 1 when main-queue plus parked messages number 8. A push while `q_full_o` is 1 is ignored.
- R10: `park_full_o` is 1 when 4 messages are parked, and `park_empty_o` is 1 when none are parked.
- R11: A message stalled in a given cycle is not released by a wake in that same cycle. The wake acts only on messages parked before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push a message into the main queue |
| push_addr_i | input | 8 | Address field of the pushed message |
| push_data_i | input | 8 | Data field of the pushed message |
| op_i | input | 2 | Head operation: 0 none, 1 dequeue, 2 recycle, 3 stall |
| wake_i | input | 1 | Release parked messages tagged with `wake_addr_i` |
| wake_all_i | input | 1 | Release all parked messages |
| wake_addr_i | input | 8 | Tag to match for `wake_i` |
| head_valid_o | output | 1 | Head view holds a message |
| head_addr_o | output | 8 | Address field of the head message |
| head_data_o | output | 8 | Data field of the head message |
| q_full_o | output | 1 | No free slot, counting parked messages |
| q_empty_o | output | 1 | Main queue is empty |
| park_full_o | output | 1 | Parking store holds 4 messages |
| park_empty_o | output | 1 | Parking store is empty |

## Verification
The assertions assume all inputs are stable around the rising edge. They also rely on the design's own gating of commands that cannot be served: operations on an empty queue, stalls into a full parking store, and pushes while full.

The bench changes inputs only on the falling edge. It deliberately issues those illegal commands, so the gated behaviour is exercised rather than avoided. A small address set (four values) in the random phase keeps tag matches and partial wakes frequent, and keeps both the parking store and the main queue regularly reaching their limits.

// File: rtl/swq_pkg.sv
package swq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_DEQ     = 2'd1,
        OP_RECYCLE = 2'd2,
        OP_STALL   = 2'd3
    } head_op_e;
endpackage

// File: rtl/swq_park.sv
module swq_park
    import swq_pkg::*;
#(
    parameter int PDEPTH = 4,
    localparam int CW = $clog2(PDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_en,
    input  msg_t              stall_msg,
    input  logic              wake_en,
    input  logic              wake_all,
    input  logic [ADDR_W-1:0] wake_addr,
    output msg_t              wk_msgs [PDEPTH],
    output logic [CW-1:0]     wk_cnt,
    output logic [CW-1:0]     cnt,
    output logic              full,
    output logic              empty
);
    msg_t          slots   [PDEPTH];
    msg_t          slots_d [PDEPTH];
    logic [CW-1:0] cnt_d;

    always_comb begin
        int kept;
        int woke;
        kept    = 0;
        woke    = 0;
        slots_d = slots;
        wk_msgs = '{default: '0};
        for (int i = 0; i < PDEPTH; i++) begin
            if (i < int'(cnt)) begin
                if (wake_all || (wake_en && slots[i].addr == wake_addr)) begin
                    wk_msgs[woke] = slots[i];
                    woke++;
                end else begin
                    slots_d[kept] = slots[i];
                    kept++;
                end
            end
        end
        if (stall_en && kept < PDEPTH) begin
            slots_d[kept] = stall_msg;
            kept++;
        end
        cnt_d  = CW'(kept);
        wk_cnt = CW'(woke);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < PDEPTH; i++) slots[i] <= '0;
        end else begin
            cnt   <= cnt_d;
            slots <= slots_d;
        end
    end

    assign full  = (int'(cnt) == PDEPTH);
    assign empty = (cnt == '0);

    p_park_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= PDEPTH);

    p_wake_all_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_all && !stall_en) |=> (cnt == '0));

    p_stall_survives_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && !full) |=> !empty);
endmodule

// File: rtl/swq_main.sv
module swq_main
    import swq_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int PDEPTH = 4,
    localparam int QCW = $clog2(QDEPTH + 1),
    localparam int PCW = $clog2(PDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pop,
    input  logic           rcy,
    input  msg_t           wk_msgs [PDEPTH],
    input  logic [PCW-1:0] wk_cnt,
    input  logic           push_en,
    input  msg_t           push_msg,
    output msg_t           head,
    output logic [QCW-1:0] cnt,
    output logic           empty
);
    msg_t           slots   [QDEPTH];
    msg_t           slots_d [QDEPTH];
    logic [QCW-1:0] cnt_d;

    always_comb begin
        int k;
        int first;
        k       = 0;
        first   = pop ? 1 : 0;
        slots_d = slots;
        for (int i = 0; i < QDEPTH; i++) begin
            if (i >= first && i < int'(cnt)) begin
                slots_d[k] = slots[i];
                k++;
            end
        end
        if (rcy && k < QDEPTH) begin
            slots_d[k] = slots[0];
            k++;
        end
        for (int w = 0; w < PDEPTH; w++) begin
            if (w < int'(wk_cnt) && k < QDEPTH) begin
                slots_d[k] = wk_msgs[w];
                k++;
            end
        end
        if (push_en && k < QDEPTH) begin
            slots_d[k] = push_msg;
            k++;
        end
        cnt_d = QCW'(k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < QDEPTH; i++) slots[i] <= '0;
        end else begin
            cnt   <= cnt_d;
            slots <= slots_d;
        end
    end

    assign head  = slots[0];
    assign empty = (cnt == '0);

    p_main_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= QDEPTH);

    p_single_deq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rcy && !push_en && wk_cnt == '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/stall_wait_queue.sv
module stall_wait_queue
    import swq_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int PDEPTH = 4,
    localparam int QCW = $clog2(QDEPTH + 1),
    localparam int PCW = $clog2(PDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [1:0]        op_i,
    input  logic              wake_i,
    input  logic              wake_all_i,
    input  logic [ADDR_W-1:0] wake_addr_i,
    output logic              head_valid_o,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              q_full_o,
    output logic              q_empty_o,
    output logic              park_full_o,
    output logic              park_empty_o
);
    msg_t           head;
    msg_t           wk_msgs [PDEPTH];
    logic [PCW-1:0] wk_cnt;
    logic [PCW-1:0] park_cnt;
    logic [QCW-1:0] main_cnt;
    head_op_e       op_act;
    logic           pop, rcy, stall_acc, push_acc;
    int             total;

    // Gate the requested head operation by what can be served this cycle.
    always_comb begin
        op_act = q_empty_o ? OP_NONE : head_op_e'(op_i);
        if (op_act == OP_STALL && park_full_o) op_act = OP_NONE;
    end

    always_comb begin
        pop       = 1'b0;
        rcy       = 1'b0;
        stall_acc = 1'b0;
        unique case (op_act)
            OP_NONE:    ;
            OP_DEQ:     pop = 1'b1;
            OP_RECYCLE: begin pop = 1'b1; rcy = 1'b1; end
            OP_STALL:   begin pop = 1'b1; stall_acc = 1'b1; end
        endcase
    end

    assign total    = int'(main_cnt) + int'(park_cnt);
    assign q_full_o = (total >= QDEPTH);
    assign push_acc = push_i && !q_full_o;

    swq_park #(.PDEPTH(PDEPTH)) u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_en  (stall_acc),
        .stall_msg (head),
        .wake_en   (wake_i),
        .wake_all  (wake_all_i),
        .wake_addr (wake_addr_i),
        .wk_msgs   (wk_msgs),
        .wk_cnt    (wk_cnt),
        .cnt       (park_cnt),
        .full      (park_full_o),
        .empty     (park_empty_o)
    );

    swq_main #(.QDEPTH(QDEPTH), .PDEPTH(PDEPTH)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (pop),
        .rcy      (rcy),
        .wk_msgs  (wk_msgs),
        .wk_cnt   (wk_cnt),
        .push_en  (push_acc),
        .push_msg ('{addr: push_addr_i, data: push_data_i}),
        .head     (head),
        .cnt      (main_cnt),
        .empty    (q_empty_o)
    );

    assign head_valid_o = !q_empty_o;
    assign head_addr_o  = head.addr;
    assign head_data_o  = head.data;

    p_total_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_acc && op_act != OP_DEQ) |=> (total == $past(total)));

    p_stall_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd3 && !q_empty_o && park_full_o && !wake_i && !wake_all_i)
            |=> $stable(park_cnt));

    p_push_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full_o && op_i == 2'd0) |=> q_full_o);
endmodule

// File: tb/stall_wait_queue_bench.sv
`timescale 1ns/1ps
module stall_wait_queue_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_addr_i = '0, push_data_i = '0, wake_addr_i = '0;
    logic [1:0] op_i = '0;
    logic       wake_i = 1'b0, wake_all_i = 1'b0;
    logic       head_valid_o, q_full_o, q_empty_o, park_full_o, park_empty_o;
    logic [7:0] head_addr_o, head_data_o;

    int    total_checks = 0;
    int    bad_checks = 0;
    string cur_req = "R1";
    string prev_req = "R1";
    bit    done = 1'b0;

    logic [15:0] mq[$];
    logic [15:0] pq[$];

    always #2 clk = ~clk;

    stall_wait_queue u_stall_wait_queue (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
        .push_data_i(push_data_i), .op_i(op_i), .wake_i(wake_i),
        .wake_all_i(wake_all_i), .wake_addr_i(wake_addr_i),
        .head_valid_o(head_valid_o), .head_addr_o(head_addr_o),
        .head_data_o(head_data_o), .q_full_o(q_full_o), .q_empty_o(q_empty_o),
        .park_full_o(park_full_o), .park_empty_o(park_empty_o)
    );

    // Behavioural reference: two ordered lists updated on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq = {};
            pq = {};
        end else begin
            logic [15:0] h;
            logic [15:0] nm[$];
            logic [15:0] np[$];
            logic [15:0] wk[$];
            bit nonempty, qfull, pfull;
            nm = {}; np = {}; wk = {};
            nonempty = (mq.size() > 0);
            qfull    = (mq.size() + pq.size()) >= 8;
            pfull    = (pq.size() == 4);
            h        = nonempty ? mq[0] : 16'h0;
            foreach (pq[i]) begin
                if (wake_all_i || (wake_i && pq[i][15:8] == wake_addr_i)) wk.push_back(pq[i]);
                else np.push_back(pq[i]);
            end
            foreach (mq[i]) if (!(nonempty && op_i != 2'd0 && i == 0 &&
                                  !(op_i == 2'd3 && pfull))) nm.push_back(mq[i]);
            if (nonempty && op_i == 2'd2) nm.push_back(h);
            foreach (wk[i]) nm.push_back(wk[i]);
            if (push_i && !qfull) nm.push_back({push_addr_i, push_data_i});
            if (nonempty && op_i == 2'd3 && !pfull) np.push_back(h);
            mq = nm;
            pq = np;
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        total_checks++;
        if (act !== exp) begin
            bad_checks++;
            $display("FAIL %s %s actual=%h expected=%h", prev_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("head_valid", {7'd0, head_valid_o}, {7'd0, mq.size() > 0});
        chk("q_empty", {7'd0, q_empty_o}, {7'd0, mq.size() == 0});
        chk("q_full", {7'd0, q_full_o}, {7'd0, (mq.size() + pq.size()) >= 8});
        chk("park_full", {7'd0, park_full_o}, {7'd0, pq.size() == 4});
        chk("park_empty", {7'd0, park_empty_o}, {7'd0, pq.size() == 0});
        if (mq.size() > 0) begin
            chk("head_addr", head_addr_o, mq[0][15:8]);
            chk("head_data", head_data_o, mq[0][7:0]);
        end
    endtask

    task automatic step(input bit p, input logic [7:0] a, input logic [7:0] d,
                        input logic [1:0] o, input bit w, input bit wa,
                        input logic [7:0] waddr);
        @(negedge clk);
        compare();
        prev_req    = cur_req;
        push_i      = p;
        push_addr_i = a;
        push_data_i = d;
        op_i        = o;
        wake_i      = w;
        wake_all_i  = wa;
        wake_addr_i = waddr;
    endtask

    task automatic idle(); step(0, 8'h0, 8'h0, 2'd0, 0, 0, 8'h0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad_checks++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(); idle();
        // R3: operations on an empty queue are ignored
        cur_req = "R3";
        for (int o = 1; o < 4; o++) step(0, 8'h0, 8'h0, 2'(o), 0, 0, 8'h0);
        idle();
        // R2: pushes in order
        cur_req = "R2";
        for (int i = 0; i < 3; i++) step(1, 8'(8'h10 + i), 8'(8'hA0 + i), 2'd0, 0, 0, 8'h0);
        idle();
        // R3: dequeue one per cycle
        cur_req = "R3";
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        idle();
        // R4: recycle head to tail
        cur_req = "R4";
        step(1, 8'h21, 8'hB1, 2'd0, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd2, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd2, 0, 0, 8'h0);
        idle();
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        idle();
        // R5 and R10: fill the parking store, then a refused stall
        cur_req = "R5";
        step(1, 8'h30, 8'hC0, 2'd0, 0, 0, 8'h0);
        step(1, 8'h31, 8'hC1, 2'd0, 0, 0, 8'h0);
        step(1, 8'h30, 8'hC2, 2'd0, 0, 0, 8'h0);
        step(1, 8'h32, 8'hC3, 2'd0, 0, 0, 8'h0);
        step(1, 8'h33, 8'hC4, 2'd0, 0, 0, 8'h0);
        idle();
        cur_req = "R10";
        for (int i = 0; i < 4; i++) step(0, 8'h0, 8'h0, 2'd3, 0, 0, 8'h0);
        idle();
        cur_req = "R5";
        step(0, 8'h0, 8'h0, 2'd3, 0, 0, 8'h0);
        idle();
        // R6: wake by tag releases both 0x30 messages in parking order
        cur_req = "R6";
        step(0, 8'h0, 8'h0, 2'd0, 1, 0, 8'h30);
        idle();
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        idle();
        // R7: wake-all wins over tag wake
        cur_req = "R7";
        step(0, 8'h0, 8'h0, 2'd0, 1, 1, 8'h99);
        idle();
        // R9: fill total to 8, push refused
        cur_req = "R9";
        for (int i = 0; i < 6; i++) step(1, 8'(8'h40 + i), 8'(8'hD0 + i), 2'd0, 0, 0, 8'h0);
        idle();
        step(1, 8'h4F, 8'hDF, 2'd0, 0, 0, 8'h0);
        idle();
        // R8: recycle, wake and push in one cycle
        cur_req = "R8";
        step(0, 8'h0, 8'h0, 2'd3, 0, 0, 8'h0);
        step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        step(1, 8'h55, 8'hE5, 2'd2, 0, 1, 8'h0);
        idle();
        // R11: a stall and a wake on the same tag in one cycle
        cur_req = "R11";
        for (int i = 0; i < 8; i++) step(0, 8'h0, 8'h0, 2'd1, 0, 0, 8'h0);
        step(1, 8'h66, 8'hF6, 2'd0, 0, 0, 8'h0);
        idle();
        step(0, 8'h0, 8'h0, 2'd3, 1, 0, 8'h66);
        idle();
        step(0, 8'h0, 8'h0, 2'd3, 0, 1, 8'h0);
        idle(); idle();
        // R8 mixed: random traffic on a small tag set
        cur_req = "R8";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], {6'd0, r[3:2]}, r[15:8], r[5:4], r[9:6] == 4'd0,
                 r[13:10] == 4'd0, {6'd0, r[17:16]});
        end
        idle(); idle();
        finish_run();
    end
endmodule